// File: doc/BRIEF.md
# Four-State Snooping Line Coherence Controller

This block holds the coherence state of every line in a small write-back cache that sits on a shared snooping bus and keeps copies consistent by invalidating them. Each line is in one of four states: Invalid, Exclusive-clean (the only copy, matching memory), Shared-clean (matching memory, other caches may hold it) and Modified (the only copy, newer than memory). A single state array indexed by line number serves every line. The block has two request ports. The processor port carries a read or write request with a hit/miss indication from the tag logic. The snoop port carries the operation seen on the bus for a line.

All outputs are combinational from the current state and the inputs of that cycle. The processor port produces the bus command needed for its request, a victim writeback strobe and the next state of its line. The snoop port produces a data-supply strobe for cache-to-cache transfer, a writeback strobe and the next state of its line. States update on the next rising clock edge. If both ports name the same line in one cycle, the snoop takes effect first and the processor request acts on the result. With both ports idle, the two next-state outputs show the stored state of the addressed lines.

Encodings used throughout. State: 0 Invalid, 1 Exclusive-clean, 2 Shared-clean, 3 Modified. Processor op: 0 idle, 1 read, 2 write, 3 idle. Snoop op: 0 idle, 1 bus read, 2 bus write-miss, 3 bus invalidate. Bus command: 0 none, 1 read, 2 write-miss, 3 invalidate.

Top module: `snoop_line_ctl`

## Requirements
- R1: After reset every line is Invalid (state 0), as shown on the next-state outputs with both ports idle.
- R2: A processor read that misses (hit low, or line Invalid) issues bus command 1. Its line becomes Exclusive-clean (1) when shared_in is low, or Shared-clean (2) when shared_in is high.
- R3: A processor write hit on an Exclusive-clean line moves the line to Modified (3) with bus command 0.
- R4: A processor write hit on a Shared-clean line moves the line to Modified (3) and issues bus command 3.
- R5: A processor write that misses (hit low, or line Invalid) issues bus command 2 and leaves the line Modified (3), whatever shared_in says.
- R6: A processor read hit on a valid line, a write hit on a Modified line, and an idle processor port all issue bus command 0 and leave the state unchanged.
- R7: A snooped bus read moves a Modified or Exclusive-clean line to Shared-clean, and leaves a Shared-clean line Shared-clean.
- R8: A snooped write-miss or invalidate moves any valid line to Invalid. Any snoop on an Invalid line changes nothing and raises no strobe.
- R9: snp_supply is high exactly when a snooped bus read or write-miss finds its line valid.
- R10: snp_wb is high exactly when a snooped bus read or write-miss finds its line Modified, and then always together with snp_supply.
- R11: When both ports address the same line in one cycle, the processor request is evaluated on the post-snoop state, and the stored result is the processor's next state.
- R12: A processor miss (hit low) on a line that is currently Modified raises cpu_evict_wb in that cycle. It stays low for every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_op | input | 2 | Processor operation (0 idle, 1 read, 2 write, 3 idle) |
| cpu_line | input | LW | Line addressed by the processor |
| cpu_hit | input | 1 | Tag match reported for the processor request |
| shared_in | input | 1 | High when another cache reports holding the line |
| snp_op | input | 2 | Snooped bus operation (0 idle, 1 read, 2 write-miss, 3 invalidate) |
| snp_line | input | LW | Line addressed by the snoop |
| bus_cmd | output | 2 | Bus command for the processor request (0 none, 1 read, 2 write-miss, 3 invalidate) |
| cpu_evict_wb | output | 1 | Write the Modified victim back to memory |
| snp_supply | output | 1 | Drive this cache's copy onto the bus |
| snp_wb | output | 1 | Update memory with the supplied Modified data |
| cpu_state_nxt | output | 2 | Next state of the processor's line |
| snp_state_nxt | output | 2 | Next state of the snooped line as set by the snoop alone |

## Verification
The hardest case to reach is a collision. Both ports must name the same line in one cycle, and the line must already sit in a state where the order matters: a snoop read on an Exclusive-clean line together with a write hit, or a snoop write-miss on a Modified line together with a read hit. Directed sequences first walk a line into each state. They then fire the colliding pair, so the processor's command comes out as an invalidate or a fresh read instead of a silent hit. A long random phase then runs with only four distinct lines, mostly hits, and a forced collision about every eighth cycle. It is compared every cycle against a behavioural model that applies the snoop before the request.

// File: rtl/snoop_line_ctl.sv
module snoop_line_ctl #(
  parameter int NLINES = 8,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_op,
  input  logic [LW-1:0] cpu_line,
  input  logic          cpu_hit,
  input  logic          shared_in,
  input  logic [1:0]    snp_op,
  input  logic [LW-1:0] snp_line,
  output logic [1:0]    bus_cmd,
  output logic          cpu_evict_wb,
  output logic          snp_supply,
  output logic          snp_wb,
  output logic [1:0]    cpu_state_nxt,
  output logic [1:0]    snp_state_nxt
);

  localparam logic [1:0] ST_I = 2'd0, ST_E = 2'd1, ST_S = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_RD = 2'd1, OP_WR = 2'd2;
  localparam logic [1:0] SN_RD = 2'd1, SN_WM = 2'd2, SN_INV = 2'd3;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_WM = 2'd2, CMD_INV = 2'd3;

  logic [1:0] st [NLINES];
  logic [1:0] s_cur, c_cur;
  logic       collide, c_hit;

  assign s_cur = st[snp_line];

  always_comb begin
    snp_state_nxt = s_cur;
    snp_supply    = 1'b0;
    snp_wb        = 1'b0;
    if (s_cur != ST_I) begin
      case (snp_op)
        SN_RD: begin
          snp_supply    = 1'b1;
          snp_wb        = (s_cur == ST_M);
          snp_state_nxt = ST_S;
        end
        SN_WM: begin
          snp_supply    = 1'b1;
          snp_wb        = (s_cur == ST_M);
          snp_state_nxt = ST_I;
        end
        SN_INV:  snp_state_nxt = ST_I;
        default: ;
      endcase
    end
  end

  assign collide = (snp_op != 2'd0) && (snp_line == cpu_line);
  assign c_cur   = collide ? snp_state_nxt : st[cpu_line];
  assign c_hit   = cpu_hit && (c_cur != ST_I);

  always_comb begin
    cpu_state_nxt = c_cur;
    bus_cmd       = CMD_NONE;
    cpu_evict_wb  = 1'b0;
    if (cpu_op == OP_RD && !c_hit) begin
      bus_cmd       = CMD_RD;
      cpu_evict_wb  = (c_cur == ST_M);
      cpu_state_nxt = shared_in ? ST_S : ST_E;
    end else if (cpu_op == OP_WR) begin
      cpu_state_nxt = ST_M;
      if (!c_hit) begin
        bus_cmd      = CMD_WM;
        cpu_evict_wb = (c_cur == ST_M);
      end else if (c_cur == ST_S) begin
        bus_cmd = CMD_INV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st[i] <= ST_I;
    end else begin
      if (snp_op != 2'd0) st[snp_line] <= snp_state_nxt;
      if (cpu_op == OP_RD || cpu_op == OP_WR) st[cpu_line] <= cpu_state_nxt;
    end
  end

  p_read_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op == OP_RD && bus_cmd == CMD_RD) |=>
      st[$past(cpu_line)] == ($past(shared_in) ? ST_S : ST_E));

  p_silent_upgrade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op == OP_WR && cpu_hit && c_cur == ST_E) |-> (bus_cmd == CMD_NONE));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_op != OP_RD && cpu_op != OP_WR) |-> (bus_cmd == CMD_NONE && !cpu_evict_wb));

  p_snoop_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_op == SN_WM || snp_op == SN_INV) &&
     !((cpu_op == OP_RD || cpu_op == OP_WR) && cpu_line == snp_line)) |=>
      st[$past(snp_line)] == ST_I);

  p_wb_with_supply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb |-> snp_supply);

endmodule

// File: tb/snoop_line_ctl_bench.sv
module snoop_line_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cpu_op = 0, snp_op = 0;
  logic [LW-1:0] cpu_line = 0, snp_line = 0;
  logic cpu_hit = 0, shared_in = 0;
  logic [1:0] bus_cmd, cpu_state_nxt, snp_state_nxt;
  logic cpu_evict_wb, snp_supply, snp_wb;

  int vectors = 0;
  int miscompares = 0;
  int ms [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_line_ctl #(.NLINES(NL)) u_snoop_line_ctl (
    .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_line(cpu_line),
    .cpu_hit(cpu_hit), .shared_in(shared_in), .snp_op(snp_op),
    .snp_line(snp_line), .bus_cmd(bus_cmd), .cpu_evict_wb(cpu_evict_wb),
    .snp_supply(snp_supply), .snp_wb(snp_wb),
    .cpu_state_nxt(cpu_state_nxt), .snp_state_nxt(snp_state_nxt));

  task automatic chk(string rq, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic step(int cop, int cl, int hit, int shr, int sop, int sl, string idle_tag);
    int s, sn, sup, wb, c, cn, bus, ev;
    int tmp [NL];
    string rs, rc;
    @(negedge clk);
    cpu_op = cop[1:0]; cpu_line = cl[LW-1:0]; cpu_hit = hit[0];
    shared_in = shr[0]; snp_op = sop[1:0]; snp_line = sl[LW-1:0];
    s = ms[sl]; sn = s; sup = 0; wb = 0; rs = idle_tag;
    if (sop != 0) begin
      rs = (sop == 1) ? "R7" : "R8";
      if (s != 0) begin
        if (sop == 1) begin sup = 1; wb = (s == 3); sn = 2; end
        else if (sop == 2) begin sup = 1; wb = (s == 3); sn = 0; end
        else sn = 0;
      end
    end
    foreach (ms[i]) tmp[i] = ms[i];
    tmp[sl] = sn;
    c = tmp[cl]; cn = c; bus = 0; ev = 0; rc = idle_tag;
    if (cop == 1) begin
      if (hit == 1 && c != 0) rc = "R6";
      else begin rc = (c == 3) ? "R12" : "R2"; bus = 1; ev = (c == 3); cn = shr ? 2 : 1; end
    end else if (cop == 2) begin
      cn = 3;
      if (hit == 1 && c != 0) begin
        if (c == 1) rc = "R3";
        else if (c == 2) begin rc = "R4"; bus = 3; end
        else rc = "R6";
      end else begin rc = (c == 3) ? "R12" : "R5"; bus = 2; ev = (c == 3); end
    end
    if (sop != 0 && (cop == 1 || cop == 2) && cl == sl) rc = "R11";
    #1;
    chk(rs, "snp_state_nxt", snp_state_nxt, sn);
    chk((sop == 0) ? rs : "R9", "snp_supply", snp_supply, sup);
    chk((sop == 0) ? rs : "R10", "snp_wb", snp_wb, wb);
    chk(rc, "cpu_state_nxt", cpu_state_nxt, cn);
    chk(rc, "bus_cmd", bus_cmd, bus);
    chk((cop == 0) ? rc : "R12", "cpu_evict_wb", cpu_evict_wb, ev);
    @(posedge clk);
    foreach (ms[i]) ms[i] = tmp[i];
    if (cop == 1 || cop == 2) ms[cl] = cn;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    foreach (ms[i]) ms[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: every line Invalid after reset
    for (int i = 0; i < NL; i++) step(0, i, 0, 0, 0, (i + 1) % NL, "R1");
    // R2: read miss without and with sharers
    step(1, 0, 0, 0, 0, 7, "R2");
    step(1, 1, 0, 1, 0, 7, "R2");
    // R3 / R4: write hits on Exclusive and Shared
    step(2, 0, 1, 0, 0, 7, "R3");
    step(2, 1, 1, 0, 0, 7, "R4");
    // R6: read hit and write hit on Modified stay quiet
    step(1, 0, 1, 1, 0, 7, "R6");
    step(2, 0, 1, 1, 0, 7, "R6");
    // R5: write miss with sharers still Modified
    step(2, 2, 0, 1, 0, 7, "R5");
    // R7 / R9 / R10: snoop read on Modified
    step(0, 5, 0, 0, 1, 0, "R7");
    // R8: snoop write-miss on Shared, then invalidate on Invalid
    step(0, 5, 0, 0, 2, 0, "R8");
    step(0, 0, 0, 0, 3, 0, "R8");
    step(0, 0, 0, 0, 1, 6, "R8");
    // R11: snoop read on Exclusive collides with write hit
    step(1, 3, 0, 0, 0, 7, "R11");
    step(2, 3, 1, 0, 1, 3, "R11");
    // R11: snoop write-miss on Modified collides with read hit
    step(1, 3, 1, 0, 2, 3, "R11");
    // R12: miss on a Modified line evicts it
    step(2, 4, 0, 0, 0, 7, "R12");
    step(1, 4, 0, 1, 0, 7, "R12");
    // random traffic over four lines
    for (int n = 0; n < 4000; n++) begin
      int cl, sl;
      cl = $urandom_range(0, 3);
      sl = ($urandom_range(0, 7) == 0) ? cl : $urandom_range(0, 3);
      step($urandom_range(0, 3), cl, ($urandom_range(0, 4) != 0), $urandom_range(0, 1),
           $urandom_range(0, 3), sl, "R6");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule